// File: doc/BRIEF.md
# Dual-Channel Transmit Queue

This block is the host side of a simple Ethernet transmitter. It holds two byte queues. Each queue has its own frame-length register. A host write port selects which queue receives 32-bit data words, programs each queue's length and fires a per-queue trigger. A host read port returns the register contents and the fill level of each queue one cycle after the address is presented.

When a queue is triggered, the block streams its bytes out on a byte-wide frame port. The port has valid/ready handshaking and first-byte and last-byte markers. The number of bytes sent is the programmed length or the number of bytes held, whichever is smaller. When a frame completes, the block empties that queue, zeroes its length and latches a per-queue completion flag. The completion flags drive a masked interrupt line, and the host clears a flag by writing a one to its bit. A software reset bit in the control register returns all queue state to idle.

Framing, preamble, CRC and the line interface belong to other blocks.

Top module: `txq_dual`

## Requirements
- R1: A write to the select register (offset 2) with a value of 0 or 1 selects that queue. Any larger value selects queue 0. Reading offset 2 returns the selection.
- R2: A write to the data register (offset 7) appends four bytes to the selected queue, least significant byte first. Those bytes later leave in that order. Reads at offsets 10 and 11 return the fill levels of queues 0 and 1 in bytes.
- R3: When fewer than four bytes are free in the selected queue, a data write is dropped whole and the fill level does not change. The queue size is the parameter DEPTH_BYTES (default 4096).
- R4: A write to a length register (offset 3 for queue 0, 4 for queue 1) larger than DEPTH_BYTES stores DEPTH_BYTES. Any other value is stored as written. The same offsets read the stored length back.
- R5: A write with bit 0 set to a trigger register (offset 5 for queue 0, 6 for queue 1) starts a frame only when control bit 1 (transmit enable, offset 0) is set. Otherwise the queue and its length are left untouched.
- R6: A started frame carries min(length, fill) bytes. When that number is zero, no byte is sent and no flag is set.
- R7: After the last byte of a frame is accepted, the queue's fill level and length read 0, and its completion flag is set. The flag is bit 0 for queue 0 and bit 1 for queue 1 of the status register (offset 9).
- R8: The irq output is high one cycle after status AND mask (offset 8) becomes nonzero. Writing the status register clears every flag written as 1.
- R9: A control write with bit 0 set empties both queues, zeroes both lengths, and clears the selection, the mode register (offset 1), the mask and the status. It also aborts any frame in flight. Control is then loaded with the written value with bit 0 cleared.
- R10: The frame port delivers one byte per cycle in which fo_valid and fo_ready are both high. While fo_ready is low, the data and markers are held. fo_sof marks the first byte of a frame and fo_eof marks the last.
- R11: A trigger on a queue that is still waiting or still sending is ignored. A trigger on the other queue is held and its frame follows once the current one ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Host write strobe |
| hw_addr | input | 4 | Host write word offset |
| hw_data | input | 32 | Host write data |
| hr_addr | input | 4 | Host read word offset |
| hr_data | output | 32 | Registered read data for the previous cycle's hr_addr |
| irq | output | 1 | Masked completion interrupt |
| fo_valid | output | 1 | Frame byte valid |
| fo_ready | input | 1 | Frame byte accepted by the sink |
| fo_data | output | 8 | Frame byte |
| fo_sof | output | 1 | First byte of a frame |
| fo_eof | output | 1 | Last byte of a frame |

## Verification
The send path is tried with three kinds of frame:
- A frame shorter than the data held, which shows that the length truncates the frame.
- A frame whose length exceeds the data held, which shows that the fill level caps it.
- A frame with nothing queued, which shows that no output and no flag result.

Byte order inside each word and the markers are checked under a sink that alternates ready and under one that stalls for a long time. Two queued frames on different queues, with a redundant retrigger in between, show that the two channels are kept apart and that the retrigger is ignored. Filling a queue to the brim, software reset, the transmit-enable gate and the select and length clamps each get their own directed pattern.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_MODE  = 4'd1;
  localparam logic [3:0] A_CHSEL = 4'd2;
  localparam logic [3:0] A_LEN0  = 4'd3;
  localparam logic [3:0] A_LEN1  = 4'd4;
  localparam logic [3:0] A_GO0   = 4'd5;
  localparam logic [3:0] A_GO1   = 4'd6;
  localparam logic [3:0] A_DATA  = 4'd7;
  localparam logic [3:0] A_MASK  = 4'd8;
  localparam logic [3:0] A_STAT  = 4'd9;
  localparam logic [3:0] A_FILL0 = 4'd10;
  localparam logic [3:0] A_FILL1 = 4'd11;

  localparam int NCH          = 2;
  localparam int CTRL_RST_BIT = 0;
  localparam int CTRL_TXEN_BIT = 1;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND} snd_state_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH_BYTES = 4096,
  parameter int IDX_W       = 10,
  parameter int FILL_W      = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [31:0]       push_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_word,
  output logic [FILL_W-1:0] fill
);
  localparam int WORDS = DEPTH_BYTES / 4;
  localparam logic [IDX_W:0] WORDS_L = (IDX_W+1)'(WORDS);

  logic [31:0]    mem [WORDS];
  logic [IDX_W:0] wcnt;
  logic           full;
  logic           take;

  assign full = (wcnt == WORDS_L);
  assign take = push && !full && !clr;
  assign fill = {wcnt, 2'b00};

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (take) mem[wcnt[IDX_W-1:0]] <= push_word;
    rd_word <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) wcnt <= '0;
    else if (take)  wcnt <= wcnt + 1'b1;
  end
endmodule

// File: rtl/txq_sender.sv
module txq_sender
  import txq_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int FILL_W = 13
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        abort,
  input  logic [NCH-1:0]              start,
  input  logic [NCH-1:0][FILL_W-1:0]  start_len,
  input  logic [31:0]                 rd_word0,
  input  logic [31:0]                 rd_word1,
  output logic [IDX_W-1:0]            rd_idx,
  output logic [NCH-1:0]              busy,
  output logic [NCH-1:0]              done,
  input  logic                        fo_ready,
  output logic                        fo_valid,
  output logic [7:0]                  fo_data,
  output logic                        fo_sof,
  output logic                        fo_eof
);
  snd_state_t                 st;
  logic [NCH-1:0]             pend;
  logic [NCH-1:0]             done_q;
  logic [NCH-1:0][FILL_W-1:0] plen;
  logic                       ch;
  logic [FILL_W-1:0]          rem;
  logic [1:0]                 lane;
  logic                       first;
  logic [IDX_W-1:0]           idx;
  logic [31:0]                word;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st     <= S_IDLE;
      pend   <= '0;
      done_q <= '0;
      plen   <= '0;
      ch     <= 1'b0;
      rem    <= '0;
      lane   <= '0;
      first  <= 1'b0;
      idx    <= '0;
    end else begin
      done_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        if (start[c]) begin
          pend[c] <= 1'b1;
          plen[c] <= start_len[c];
        end
      end
      case (st)
        S_IDLE: begin
          if (pend[0] || pend[1]) begin
            ch    <= !pend[0];
            rem   <= pend[0] ? plen[0] : plen[1];
            idx   <= '0;
            lane  <= '0;
            first <= 1'b1;
            st    <= S_FETCH;
          end
        end
        S_FETCH: st <= S_SEND;
        S_SEND: begin
          if (fo_ready) begin
            first <= 1'b0;
            rem   <= rem - 1'b1;
            if (rem == FILL_W'(1)) begin
              st         <= S_IDLE;
              pend[ch]   <= 1'b0;
              done_q[ch] <= 1'b1;
            end else if (lane == 2'd3) begin
              lane <= '0;
              idx  <= idx + 1'b1;
              st   <= S_FETCH;
            end else begin
              lane <= lane + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = pend | done_q;
  assign done     = done_q;
  assign rd_idx   = idx;
  assign word     = ch ? rd_word1 : rd_word0;
  assign fo_valid = (st == S_SEND);
  assign fo_data  = word[{lane, 3'b000} +: 8];
  assign fo_sof   = fo_valid && first;
  assign fo_eof   = fo_valid && (rem == FILL_W'(1));
endmodule

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
#(
  parameter int DEPTH_BYTES = 4096,
  parameter int FILL_W      = 13
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hw_en,
  input  logic [3:0]                  hw_addr,
  input  logic [31:0]                 hw_data,
  input  logic [3:0]                  hr_addr,
  output logic [31:0]                 hr_data,
  output logic                        irq,
  input  logic [NCH-1:0][FILL_W-1:0]  fill,
  input  logic [NCH-1:0]              busy,
  input  logic [NCH-1:0]              done,
  output logic                        chsel,
  output logic [NCH-1:0]              push,
  output logic [31:0]                 push_word,
  output logic [NCH-1:0]              clr,
  output logic [NCH-1:0]              start,
  output logic [NCH-1:0][FILL_W-1:0]  start_len,
  output logic                        abort
);
  localparam logic [FILL_W-1:0] DEPTH_L = FILL_W'(DEPTH_BYTES);

  logic [31:0]                ctrl;
  logic [31:0]                mode;
  logic [NCH-1:0]             mask;
  logic [NCH-1:0]             stat;
  logic [NCH-1:0][FILL_W-1:0] len;
  logic [NCH-1:0][FILL_W-1:0] cnt;
  logic [FILL_W-1:0]          len_in;
  logic [NCH-1:0]             w1c;

  assign abort     = hw_en && (hw_addr == A_CTRL) && hw_data[CTRL_RST_BIT];
  assign push_word = hw_data;
  assign len_in    = (hw_data > 32'(DEPTH_BYTES)) ? DEPTH_L : hw_data[FILL_W-1:0];
  assign w1c       = (hw_en && hw_addr == A_STAT) ? hw_data[NCH-1:0] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cnt[c]       = (len[c] < fill[c]) ? len[c] : fill[c];
    assign start_len[c] = cnt[c];
    assign push[c]      = hw_en && (hw_addr == A_DATA) && (chsel == c[0]);
    assign clr[c]       = abort || done[c];
    assign start[c]     = hw_en && (hw_addr == (c == 0 ? A_GO0 : A_GO1)) && hw_data[0] &&
                          ctrl[CTRL_TXEN_BIT] && !busy[c] && (cnt[c] != '0);

    always_ff @(posedge clk) begin
      if (rst || abort || done[c]) len[c] <= '0;
      else if (hw_en && hw_addr == (c == 0 ? A_LEN0 : A_LEN1)) len[c] <= len_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      mode  <= '0;
      chsel <= 1'b0;
      mask  <= '0;
      stat  <= '0;
    end else if (abort) begin
      ctrl  <= hw_data & ~(32'd1 << CTRL_RST_BIT);
      mode  <= '0;
      chsel <= 1'b0;
      mask  <= '0;
      stat  <= '0;
    end else begin
      if (hw_en && hw_addr == A_CTRL)  ctrl  <= hw_data;
      if (hw_en && hw_addr == A_MODE)  mode  <= hw_data;
      if (hw_en && hw_addr == A_CHSEL) chsel <= (hw_data < 32'd2) ? hw_data[0] : 1'b0;
      if (hw_en && hw_addr == A_MASK)  mask  <= hw_data[NCH-1:0];
      stat <= (stat & ~w1c) | done;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      hr_data <= '0;
    end else begin
      irq <= |(stat & mask);
      case (hr_addr)
        A_CTRL:  hr_data <= ctrl;
        A_MODE:  hr_data <= mode;
        A_CHSEL: hr_data <= 32'(chsel);
        A_LEN0:  hr_data <= 32'(len[0]);
        A_LEN1:  hr_data <= 32'(len[1]);
        A_MASK:  hr_data <= 32'(mask);
        A_STAT:  hr_data <= 32'(stat);
        A_FILL0: hr_data <= 32'(fill[0]);
        A_FILL1: hr_data <= 32'(fill[1]);
        default: hr_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/txq_dual.sv
module txq_dual
  import txq_pkg::*;
#(
  parameter int DEPTH_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hw_en,
  input  logic [3:0]  hw_addr,
  input  logic [31:0] hw_data,
  input  logic [3:0]  hr_addr,
  output logic [31:0] hr_data,
  output logic        irq,
  output logic        fo_valid,
  input  logic        fo_ready,
  output logic [7:0]  fo_data,
  output logic        fo_sof,
  output logic        fo_eof
);
  localparam int WORDS  = DEPTH_BYTES / 4;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int FILL_W = IDX_W + 3;

  logic                       chsel;
  logic                       abort;
  logic [NCH-1:0]             push, clr, start, busy, done;
  logic [31:0]                push_word;
  logic [NCH-1:0][FILL_W-1:0] fill, start_len;
  logic [IDX_W-1:0]           rd_idx;
  logic [31:0]                rd_word [NCH];

  txq_regs #(.DEPTH_BYTES(DEPTH_BYTES), .FILL_W(FILL_W)) u_regs (
    .clk(clk), .rst(rst), .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data),
    .hr_addr(hr_addr), .hr_data(hr_data), .irq(irq), .fill(fill), .busy(busy),
    .done(done), .chsel(chsel), .push(push), .push_word(push_word), .clr(clr),
    .start(start), .start_len(start_len), .abort(abort)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_store
    txq_store #(.DEPTH_BYTES(DEPTH_BYTES), .IDX_W(IDX_W), .FILL_W(FILL_W)) u_store (
      .clk(clk), .rst(rst), .clr(clr[g]), .push(push[g]), .push_word(push_word),
      .rd_idx(rd_idx), .rd_word(rd_word[g]), .fill(fill[g])
    );
  end

  txq_sender #(.IDX_W(IDX_W), .FILL_W(FILL_W)) u_send (
    .clk(clk), .rst(rst), .abort(abort), .start(start), .start_len(start_len),
    .rd_word0(rd_word[0]), .rd_word1(rd_word[1]), .rd_idx(rd_idx), .busy(busy),
    .done(done), .fo_ready(fo_ready), .fo_valid(fo_valid), .fo_data(fo_data),
    .fo_sof(fo_sof), .fo_eof(fo_eof)
  );
endmodule

// File: rtl/txq_dual_chk.sv
module txq_dual_chk
  import txq_pkg::*;
#(
  parameter int DEPTH_BYTES = 4096,
  parameter int FILL_W      = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              hw_en,
  input logic [3:0]        hw_addr,
  input logic [31:0]       hw_data,
  input logic              chsel,
  input logic [FILL_W-1:0] fill0,
  input logic [FILL_W-1:0] fill1,
  input logic [1:0]        done,
  input logic              irq,
  input logic              fo_valid,
  input logic              fo_ready,
  input logic [7:0]        fo_data,
  input logic              fo_eof
);
  localparam logic [FILL_W-1:0] DEPTH_L = FILL_W'(DEPTH_BYTES);

  logic soft_rst;
  assign soft_rst = hw_en && hw_addr == A_CTRL && hw_data[CTRL_RST_BIT];

  AST_SEL_WRAP: assert property (@(posedge clk) disable iff (rst)
    (hw_en && hw_addr == A_CHSEL && hw_data >= 32'd2) |=> (chsel == 1'b0)); // R1

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (hw_en && hw_addr == A_DATA && !chsel && fill0 == DEPTH_L) |=> (fill0 == DEPTH_L)); // R3

  AST_DONE_EMPTY0: assert property (@(posedge clk) disable iff (rst)
    done[0] |=> (fill0 == '0)); // R7

  AST_DONE_EMPTY1: assert property (@(posedge clk) disable iff (rst)
    done[1] |=> (fill1 == '0)); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (hw_en && hw_addr == A_MASK && hw_data[1:0] == 2'b00) |=> ##1 !irq); // R8

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fo_valid && !fo_ready && !soft_rst) |=> (fo_valid && $stable(fo_data) && $stable(fo_eof))); // R10

  AST_ONE_DONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done)); // R11
endmodule

bind txq_dual txq_dual_chk #(.DEPTH_BYTES(DEPTH_BYTES), .FILL_W(FILL_W)) u_chk (
  .clk(clk), .rst(rst), .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data),
  .chsel(chsel), .fill0(fill[0]), .fill1(fill[1]), .done(done), .irq(irq),
  .fo_valid(fo_valid), .fo_ready(fo_ready), .fo_data(fo_data), .fo_eof(fo_eof)
);

// File: tb/test_txq_dual.sv
module test_txq_dual;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hw_en = 1'b0;
  logic [3:0]  hw_addr = '0;
  logic [31:0] hw_data = '0;
  logic [3:0]  hr_addr = '0;
  logic [31:0] hr_data;
  logic        irq;
  logic        fo_valid, fo_ready, fo_sof, fo_eof;
  logic [7:0]  fo_data;

  int total = 0;
  int bad = 0;
  int rmode = 0;
  int rcnt = 0;
  int cap_n = 0;
  logic [7:0] cap_d [64];
  logic       cap_s [64];
  logic       cap_e [64];
  logic [7:0] exp_d [64];

  txq_dual #(.DEPTH_BYTES(DEPTH)) i_txq_dual (
    .clk(clk), .rst(rst), .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data),
    .hr_addr(hr_addr), .hr_data(hr_data), .irq(irq), .fo_valid(fo_valid),
    .fo_ready(fo_ready), .fo_data(fo_data), .fo_sof(fo_sof), .fo_eof(fo_eof)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    rcnt <= rcnt + 1;
    case (rmode)
      0: fo_ready <= 1'b1;
      1: fo_ready <= rcnt[0];
      2: fo_ready <= (rcnt % 3 == 0);
      default: fo_ready <= 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (!rst && fo_valid && fo_ready && cap_n < 64) begin
      cap_d[cap_n] = fo_data;
      cap_s[cap_n] = fo_sof;
      cap_e[cap_n] = fo_eof;
      cap_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    hr_addr = a;
    @(negedge clk);
    d = hr_data;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wait_bytes(input int n);
    for (int i = 0; i < 400 && cap_n < n; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic frame_chk(input string tag, input int base, input int n);
    for (int k = 0; k < n; k++) begin
      chk({tag, " data"}, 32'(cap_d[base+k]), 32'(exp_d[k]));
      chk({tag, " sof"}, 32'(cap_s[base+k]), 32'(k == 0));
      chk({tag, " eof"}, 32'(cap_e[base+k]), 32'(k == n-1));
    end
  endtask

  task automatic t_reset;
    rd_chk("R9 reset ctrl", 4'd0, 0);
    rd_chk("R1 reset sel", 4'd2, 0);
    rd_chk("R7 reset stat", 4'd9, 0);
    rd_chk("R2 reset fill0", 4'd10, 0);
    chk("R8 reset irq", 32'(irq), 0);
    chk("R10 reset valid", 32'(fo_valid), 0);
  endtask

  task automatic t_select;
    wr(4'd2, 1);
    rd_chk("R1 sel one", 4'd2, 1);
    wr(4'd2, 5);
    rd_chk("R1 sel wrap", 4'd2, 0);
  endtask

  task automatic t_basic;
    int b = cap_n;
    rmode = 1;
    wr(4'd0, 32'h2);
    wr(4'd2, 0);
    wr(4'd7, 32'h44332211);
    wr(4'd7, 32'h88776655);
    rd_chk("R2 fill after two words", 4'd10, 8);
    wr(4'd3, 6);
    wr(4'd5, 1);
    for (int k = 0; k < 6; k++) exp_d[k] = 8'(8'h11 * (k + 1));
    wait_bytes(b + 6);
    chk("R6 short frame count", cap_n - b, 6);
    frame_chk("R2 R10 short frame", b, 6);
    rd_chk("R7 fill0 cleared", 4'd10, 0);
    rd_chk("R7 len0 cleared", 4'd3, 0);
    rd_chk("R7 stat bit0", 4'd9, 1);
    rmode = 0;
  endtask

  task automatic t_irq;
    chk("R8 irq masked", 32'(irq), 0);
    wr(4'd8, 1);
    repeat (2) @(negedge clk);
    chk("R8 irq raised", 32'(irq), 1);
    wr(4'd9, 1);
    repeat (2) @(negedge clk);
    chk("R8 irq after w1c", 32'(irq), 0);
    rd_chk("R8 stat cleared", 4'd9, 0);
    wr(4'd8, 0);
  endtask

  task automatic t_fill_cap;
    int b = cap_n;
    rmode = 2;
    wr(4'd2, 1);
    wr(4'd7, 32'hDDCCBBAA);
    wr(4'd4, 100);
    wr(4'd6, 1);
    exp_d[0] = 8'hAA; exp_d[1] = 8'hBB; exp_d[2] = 8'hCC; exp_d[3] = 8'hDD;
    wait_bytes(b + 4);
    chk("R6 fill caps count", cap_n - b, 4);
    frame_chk("R6 ch1 frame", b, 4);
    rd_chk("R7 stat bit1", 4'd9, 2);
    wr(4'd9, 3);
    rmode = 0;
  endtask

  task automatic t_zero;
    int b = cap_n;
    wr(4'd3, 8);
    wr(4'd5, 1);
    repeat (20) @(negedge clk);
    chk("R6 empty queue sends nothing", cap_n - b, 0);
    rd_chk("R6 empty no flag", 4'd9, 0);
    wr(4'd3, 0);
  endtask

  task automatic t_txen;
    int b = cap_n;
    wr(4'd0, 0);
    wr(4'd2, 0);
    wr(4'd7, 32'h0D0C0B0A);
    wr(4'd3, 4);
    wr(4'd5, 1);
    repeat (20) @(negedge clk);
    chk("R5 gated no bytes", cap_n - b, 0);
    rd_chk("R5 gated fill kept", 4'd10, 4);
    rd_chk("R5 gated len kept", 4'd3, 4);
    wr(4'd0, 2);
    wr(4'd5, 1);
    exp_d[0] = 8'h0A; exp_d[1] = 8'h0B; exp_d[2] = 8'h0C; exp_d[3] = 8'h0D;
    wait_bytes(b + 4);
    chk("R5 enabled count", cap_n - b, 4);
    frame_chk("R5 enabled frame", b, 4);
    wr(4'd9, 3);
  endtask

  task automatic t_clamp;
    wr(4'd3, 5000);
    rd_chk("R4 clamp big", 4'd3, DEPTH);
    wr(4'd3, DEPTH);
    rd_chk("R4 exact depth", 4'd3, DEPTH);
    wr(4'd3, 12);
    rd_chk("R4 small", 4'd3, 12);
    wr(4'd3, 0);
  endtask

  task automatic t_full;
    wr(4'd2, 0);
    for (int i = 0; i < DEPTH/4; i++) wr(4'd7, 32'(i));
    rd_chk("R3 full level", 4'd10, DEPTH);
    wr(4'd7, 32'hFFFFFFFF);
    rd_chk("R3 overflow dropped", 4'd10, DEPTH);
  endtask

  task automatic t_softrst;
    wr(4'd1, 32'h55);
    wr(4'd8, 3);
    wr(4'd2, 1);
    wr(4'd7, 32'h1);
    wr(4'd4, 4);
    wr(4'd6, 1);
    wait_bytes(cap_n + 4);
    rd_chk("R9 pre stat", 4'd9, 2);
    wr(4'd3, 7);
    wr(4'd0, 32'h3);
    rd_chk("R9 ctrl bit0 dropped", 4'd0, 2);
    rd_chk("R9 mode cleared", 4'd1, 0);
    rd_chk("R9 sel cleared", 4'd2, 0);
    rd_chk("R9 mask cleared", 4'd8, 0);
    rd_chk("R9 stat cleared", 4'd9, 0);
    rd_chk("R9 fill0 cleared", 4'd10, 0);
    rd_chk("R9 len0 cleared", 4'd3, 0);
    chk("R9 irq low", 32'(irq), 0);
  endtask

  task automatic t_queue;
    int b = cap_n;
    rmode = 3;
    wr(4'd2, 1);
    wr(4'd7, 32'h14131211);
    wr(4'd4, 4);
    wr(4'd6, 1);
    wr(4'd2, 0);
    wr(4'd7, 32'h24232221);
    wr(4'd3, 4);
    wr(4'd5, 1);
    wr(4'd6, 1);
    wr(4'd5, 1);
    repeat (10) @(negedge clk);
    chk("R10 stalled no bytes", cap_n - b, 0);
    chk("R10 stalled valid", 32'(fo_valid), 1);
    rmode = 1;
    wait_bytes(b + 8);
    repeat (20) @(negedge clk);
    chk("R11 total bytes", cap_n - b, 8);
    for (int k = 0; k < 4; k++) exp_d[k] = 8'(8'h11 + k);
    frame_chk("R11 first ch1", b, 4);
    for (int k = 0; k < 4; k++) exp_d[k] = 8'(8'h21 + k);
    frame_chk("R11 then ch0", b + 4, 4);
    rd_chk("R11 both flags", 4'd9, 3);
    rd_chk("R11 fill1 empty", 4'd11, 0);
    rmode = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_select();
    t_basic();
    t_irq();
    t_fill_cap();
    t_zero();
    t_txen();
    t_clamp();
    t_full();
    t_softrst();
    t_queue();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule